// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger and Status Unit

This block turns the filtered input level of each general-purpose pin into a sticky interrupt status bit and a sticky wake status bit. Each pin is configured independently. It can sense edges or levels, its active-level field selects high, low or both edges, it has an enable that arms detection and a separate unmask control, and it has three wake enables, one for each sleep depth. Software clears either status bit with a write-one pulse. The unit drives one pending line per pin toward an interrupt aggregator.

A global hold window is shared by all pins. When the hold feature is on and any pin's debounce configuration is written, status capture stops on every pin for a programmed number of cycles. For the length of that window, the enable readback of every pin shows zero, so software can poll it to learn when the filters have settled. The configuration register bank and its bus are outside this block. Configuration arrives on plain input vectors, and the write and clear events arrive as single-cycle strobes.

Top module: `pin_irq_unit`

## Requirements
- R1: While reset is asserted and after it is released, every interrupt status, wake status and pending output is 0 and the hold window is inactive, whatever the inputs are.
- R2: In edge mode (level select 0), active-level code 2'b00 sets status on a 0-to-1 change of the pin level, and code 2'b01 sets status on a 1-to-0 change. Status is visible one clock after the change.
- R3: Code 2'b10 sets status on either change in edge mode and never in level mode. Code 2'b11 never sets status.
- R4: In level mode (level select 1), status is set on every clock while the pin is at its active level (code 2'b00 = high, 2'b01 = low). A clear applied while that level persists gives 0 for one cycle, after which status is 1 again.
- R5: No status is captured while the pin's enable is 0. A set status stays set when the input returns to its inactive level and when the enable drops.
- R6: A one-cycle clear pulse on the interrupt clear clears only the interrupt status, and a pulse on the wake clear clears only the wake status. A clear wins over a set in the same cycle.
- R7: A detected event also sets wake status when the sleep-state input is nonzero and the pin's matching wake-enable bit is 1. State 1 uses bit 0, state 2 uses bit 1 and state 3 uses bit 2. In state 0 no wake status is set.
- R8: Pending is 1 exactly when the unmask bit is 1 and interrupt or wake status is set. Unmask 0 hides pending but does not stop capture.
- R9: A debounce-write strobe on any pin while hold is enabled starts a window of exactly hold_len cycles. During the window no pin captures status, and a capture resumes on the first clock after it.
- R10: During the hold window, the enable readback of every pin is 0. Outside the window it equals the pin's enable.
- R11: A debounce write while hold is disabled, or with hold_len 0, opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NPINS | Filtered pin levels |
| cfg_level_mode | input | NPINS | 1 = level sensing, 0 = edge sensing |
| cfg_act_lvl | input | 2*NPINS | Active-level code per pin (00 high, 01 low, 10 both, 11 none) |
| cfg_int_en | input | NPINS | Detection enable per pin |
| cfg_unmask | input | NPINS | 1 lets status through to pending |
| cfg_wake_en | input | 3*NPINS | Wake enables per pin, bit k for sleep state k+1 |
| sleep_state | input | 2 | Current sleep depth, 0 = running |
| clr_int_sts | input | NPINS | Write-one clear strobes for interrupt status |
| clr_wake_sts | input | NPINS | Write-one clear strobes for wake status |
| db_cfg_wr | input | NPINS | Debounce-configuration write strobes |
| hold_enable | input | 1 | Enables the global hold window |
| hold_len | input | LEN_W | Hold window length in cycles |
| int_sts | output | NPINS | Sticky interrupt status |
| wake_sts | output | NPINS | Sticky wake status |
| pending | output | NPINS | Unmasked pending indication |
| int_en_rb | output | NPINS | Enable readback, 0 during hold |
| hold_active | output | 1 | Hold window in progress |

## Verification
The bench sweeps every combination of sense mode, active-level code and previous and current level on one pin. It varies the unmask bit, the wake enables and the sleep state along with them, so a design that swaps the rising and falling codes, accepts both-edge in level mode, or indexes the wake enables off by one gives a wrong status. The hold window is measured cycle by cycle. A counter that is one cycle long or short either lets a capture through at the last blocked edge or holds it back one edge too many. Other checks cover a clear while a level persists, which must drop status for exactly one cycle, and a clear held against a continuous set, which must win. A hold request while hold is off must open no window.

// File: rtl/pin_irq_pkg.sv
// Shared encodings for the per-pin interrupt unit.
// Assumes: active-level code and sleep-state code are two bits wide.
package pin_irq_pkg;
    typedef enum logic [1:0] {
        ACT_HIGH = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_BOTH = 2'b10,
        ACT_NONE = 2'b11
    } act_lvl_e;

    typedef enum logic [1:0] {
        SLP_RUN   = 2'b00,
        SLP_LIGHT = 2'b01,
        SLP_DEEP  = 2'b10,
        SLP_OFF   = 2'b11
    } sleep_e;

    localparam int WAKE_BITS = 3;
endpackage

// File: rtl/pin_irq_detect.sv
// Trigger detector for one pin: compares the level with the previous
// sample and applies the sense mode and active-level code.
// Assumes: lvl is already synchronised and filtered.
module pin_irq_detect
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       level_mode,
    input  logic [1:0] act_lvl,
    input  logic       arm,
    output logic       evt
);
    logic prev_q;
    logic hit;

    // Keep the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Decide whether the current sample is a trigger.
    always_comb begin
        hit = 1'b0;
        if (level_mode) begin
            case (act_lvl)
                ACT_HIGH: hit = lvl;
                ACT_LOW:  hit = !lvl;
                default:  hit = 1'b0;
            endcase
        end else begin
            case (act_lvl)
                ACT_HIGH: hit = lvl && !prev_q;
                ACT_LOW:  hit = !lvl && prev_q;
                ACT_BOTH: hit = lvl != prev_q;
                default:  hit = 1'b0;
            endcase
        end
        evt = arm && hit;
    end

    AST_NO_EVT_LEVEL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && act_lvl == ACT_BOTH) |-> !evt); // R3
endmodule

// File: rtl/pin_irq_status.sv
// Sticky interrupt and wake status for one pin, with write-one clears
// and the unmasked pending output.
// Assumes: clear strobes are single-cycle; clear has priority over set.
module pin_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic wake_sel,
    input  logic clr_int,
    input  logic clr_wake,
    input  logic unmask,
    output logic int_sts,
    output logic wake_sts,
    output logic pending
);
    // Interrupt status: set by events, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)       int_sts <= 1'b0;
        else if (clr_int) int_sts <= 1'b0;
        else if (evt)     int_sts <= 1'b1;
    end

    // Wake status: set by events in an enabled sleep state.
    always_ff @(posedge clk) begin
        if (!rst_n)              wake_sts <= 1'b0;
        else if (clr_wake)       wake_sts <= 1'b0;
        else if (evt && wake_sel) wake_sts <= 1'b1;
    end

    // Pending goes to the aggregator only when unmasked.
    assign pending = unmask && (int_sts || wake_sts);

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_int |=> !int_sts); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (int_sts && !clr_int) |=> int_sts); // R5
    AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wake |=> !wake_sts); // R6
endmodule

// File: rtl/pin_irq_hold.sv
// Global hold-window timer: a debounce write with hold enabled loads
// the length; the window is open while the count is nonzero.
// Assumes: a write during an open window restarts it.
module pin_irq_hold #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    logic [LEN_W-1:0] cnt_q;

    // Load on a start strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start)      cnt_q <= len;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign active = cnt_q != '0;

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> active); // R9
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active); // R11
endmodule

// File: rtl/pin_irq_unit.sv
// Per-pin interrupt trigger and status unit: one detector and one status
// cell per pin, plus a shared hold-window timer that stalls capture and
// zeroes the enable readback after debounce reconfiguration.
// Assumes: all inputs synchronous to clk; config held stable by software.
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int LEN_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPINS-1:0]           pin_lvl,
    input  logic [NPINS-1:0]           cfg_level_mode,
    input  logic [2*NPINS-1:0]         cfg_act_lvl,
    input  logic [NPINS-1:0]           cfg_int_en,
    input  logic [NPINS-1:0]           cfg_unmask,
    input  logic [WAKE_BITS*NPINS-1:0] cfg_wake_en,
    input  logic [1:0]                 sleep_state,
    input  logic [NPINS-1:0]           clr_int_sts,
    input  logic [NPINS-1:0]           clr_wake_sts,
    input  logic [NPINS-1:0]           db_cfg_wr,
    input  logic                       hold_enable,
    input  logic [LEN_W-1:0]           hold_len,
    output logic [NPINS-1:0]           int_sts,
    output logic [NPINS-1:0]           wake_sts,
    output logic [NPINS-1:0]           pending,
    output logic [NPINS-1:0]           int_en_rb,
    output logic                       hold_active
);
    logic hold_start;

    // Any debounce write starts the window when hold is enabled.
    assign hold_start = hold_enable && (|db_cfg_wr);

    pin_irq_hold #(.LEN_W(LEN_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_start),
        .len    (hold_len),
        .active (hold_active)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic                 evt;
        logic                 wake_sel;
        logic [WAKE_BITS-1:0] wbits;

        assign wbits = cfg_wake_en[i*WAKE_BITS +: WAKE_BITS];

        // Pick the wake enable that matches the current sleep depth.
        always_comb begin
            case (sleep_state)
                SLP_LIGHT: wake_sel = wbits[0];
                SLP_DEEP:  wake_sel = wbits[1];
                SLP_OFF:   wake_sel = wbits[2];
                default:   wake_sel = 1'b0;
            endcase
        end

        pin_irq_detect u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl        (pin_lvl[i]),
            .level_mode (cfg_level_mode[i]),
            .act_lvl    (cfg_act_lvl[i*2 +: 2]),
            .arm        (cfg_int_en[i] && !hold_active),
            .evt        (evt)
        );

        pin_irq_status u_sts (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt),
            .wake_sel (wake_sel),
            .clr_int  (clr_int_sts[i]),
            .clr_wake (clr_wake_sts[i]),
            .unmask   (cfg_unmask[i]),
            .int_sts  (int_sts[i]),
            .wake_sts (wake_sts[i]),
            .pending  (pending[i])
        );

        // Enable reads back as zero while the hold window is open.
        assign int_en_rb[i] = cfg_int_en[i] && !hold_active;

        AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_active && !clr_int_sts[i]) |=> int_sts[i] == $past(int_sts[i])); // R9
        AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_int_en[i] && !int_sts[i]) |=> !int_sts[i]); // R5
    end
endmodule

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;
    localparam int N = 4;
    localparam int LW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0, cfg_level_mode = '0, cfg_int_en = '0, cfg_unmask = '0;
    logic [2*N-1:0] cfg_act_lvl = '0;
    logic [3*N-1:0] cfg_wake_en = '0;
    logic [1:0] sleep_state = '0;
    logic [N-1:0] clr_int_sts = '0, clr_wake_sts = '0, db_cfg_wr = '0;
    logic hold_enable = 1'b0;
    logic [LW-1:0] hold_len = '0;
    logic [N-1:0] int_sts, wake_sts, pending, int_en_rb;
    logic hold_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pin_irq_unit #(.NPINS(N), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_level_mode(cfg_level_mode),
        .cfg_act_lvl(cfg_act_lvl), .cfg_int_en(cfg_int_en), .cfg_unmask(cfg_unmask),
        .cfg_wake_en(cfg_wake_en), .sleep_state(sleep_state), .clr_int_sts(clr_int_sts),
        .clr_wake_sts(clr_wake_sts), .db_cfg_wr(db_cfg_wr), .hold_enable(hold_enable),
        .hold_len(hold_len), .int_sts(int_sts), .wake_sts(wake_sts), .pending(pending),
        .int_en_rb(int_en_rb), .hold_active(hold_active));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic exp_evt(input logic lt, input logic [1:0] al, input logic p, input logic c);
        if (lt) return (al == 2'b00) ? c : (al == 2'b01) ? !c : 1'b0;
        case (al)
            2'b00: return !p && c;
            2'b01: return p && !c;
            2'b10: return p != c;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset with active stimulus
        @(negedge clk);
        pin_lvl = '1; cfg_level_mode = '1; cfg_int_en = '1; cfg_unmask = '1;
        cfg_wake_en = '1; sleep_state = 2'd1; hold_enable = 1'b1; hold_len = 12'd3; db_cfg_wr = '1;
        step(); step();
        chk("R1 int_sts in reset", int_sts, 0);
        chk("R1 wake_sts in reset", wake_sts, 0);
        chk("R1 pending in reset", pending, 0);
        chk("R1 hold in reset", hold_active, 0);
        pin_lvl = '0; cfg_level_mode = '0; cfg_int_en = '0; cfg_unmask = '0;
        cfg_wake_en = '0; sleep_state = 0; hold_enable = 0; hold_len = 0; db_cfg_wr = '0;
        rst_n = 1'b1;
        step();
        chk("R1 int_sts after reset", int_sts, 0);
        chk("R1 hold after reset", hold_active, 0);

        // R2 R3 R7 R8: sweep mode x code x prev x cur on pin 0
        for (int lt = 0; lt < 2; lt++)
            for (int al = 0; al < 4; al++)
                for (int p = 0; p < 2; p++)
                    for (int c = 0; c < 2; c++) begin
                        logic e, m, ws;
                        logic [2:0] w;
                        cfg_int_en[0] = 0; pin_lvl[0] = p[0];
                        step(); step();
                        clr_int_sts[0] = 1; clr_wake_sts[0] = 1;
                        step();
                        clr_int_sts[0] = 0; clr_wake_sts[0] = 0;
                        m = p[0] ^ c[0] ^ al[0];
                        w = 3'b101 ^ {p[0], c[0], lt[0]};
                        cfg_level_mode[0] = lt[0]; cfg_act_lvl[1:0] = al[1:0];
                        cfg_unmask[0] = m; cfg_wake_en[2:0] = w; sleep_state = al[1:0];
                        cfg_int_en[0] = 1; pin_lvl[0] = c[0];
                        step();
                        e = exp_evt(lt[0], al[1:0], p[0], c[0]);
                        ws = e && (al != 0) && w[al-1];
                        chk($sformatf("R2/R3 int lt=%0d al=%0d p=%0d c=%0d", lt, al, p, c), int_sts[0], e);
                        chk($sformatf("R7 wake lt=%0d al=%0d p=%0d c=%0d", lt, al, p, c), wake_sts[0], ws);
                        chk($sformatf("R8 pending m=%0d", m), pending[0], m && (e || ws));
                        cfg_int_en[0] = 0;
                    end
        cfg_wake_en = '0; sleep_state = 0; cfg_unmask = '0;

        // R4: level-low on pin 1, clear while level persists
        cfg_level_mode[1] = 1; cfg_act_lvl[3:2] = 2'b01; pin_lvl[1] = 0; cfg_int_en[1] = 1;
        step();
        chk("R4 level set", int_sts[1], 1);
        clr_int_sts[1] = 1; step(); clr_int_sts[1] = 0;
        chk("R4 clear one cycle", int_sts[1], 0);
        step();
        chk("R4 sets again", int_sts[1], 1);
        // R6: held clear wins over continuous set
        clr_int_sts[1] = 1; step(); step();
        chk("R6 clear wins", int_sts[1], 0);
        clr_int_sts[1] = 0; step();
        // R5: sticky after level inactive and enable dropped
        cfg_int_en[1] = 0; pin_lvl[1] = 1; step(); step();
        chk("R5 sticky", int_sts[1], 1);
        clr_int_sts[1] = 1; step(); clr_int_sts[1] = 0; pin_lvl[1] = 0; step(); step();
        chk("R5 no capture when disabled", int_sts[1], 0);
        // R8: unmask 0 hides pending but capture continues
        cfg_unmask[1] = 0; cfg_int_en[1] = 1; step();
        chk("R8 captured while masked", int_sts[1], 1);
        chk("R8 pending masked", pending[1], 0);
        cfg_unmask[1] = 1; #1;
        chk("R8 pending unmasked", pending[1], 1);
        // R6/R7: wake on state 2 (bit 1), separate clears
        sleep_state = 2'd2; cfg_wake_en[5:3] = 3'b010; step();
        chk("R7 wake state2 bit1", wake_sts[1], 1);
        cfg_int_en[1] = 0; clr_int_sts[1] = 1; step(); clr_int_sts[1] = 0;
        chk("R6 int cleared", int_sts[1], 0);
        chk("R6 wake kept", wake_sts[1], 1);
        clr_wake_sts[1] = 1; step(); clr_wake_sts[1] = 0;
        chk("R6 wake cleared", wake_sts[1], 0);
        sleep_state = 0; cfg_wake_en = '0;

        // R9 R10: hold window of 5 cycles, level-high on pin 0
        cfg_level_mode[0] = 1; cfg_act_lvl[1:0] = 2'b00; pin_lvl[0] = 0; cfg_int_en[0] = 1;
        clr_int_sts[0] = 1; step(); clr_int_sts[0] = 0;
        hold_enable = 1; hold_len = 12'd5; db_cfg_wr[3] = 1;
        step();
        db_cfg_wr[3] = 0;
        chk("R9 hold open", hold_active, 1);
        chk("R10 enable reads zero", int_en_rb[0], 0);
        pin_lvl[0] = 1;
        for (int k = 1; k <= 5; k++) begin
            step();
            chk($sformatf("R9 blocked k=%0d", k), int_sts[0], 0);
            chk($sformatf("R10 readback k=%0d", k), int_en_rb[0], (k == 5) ? 1 : 0);
        end
        chk("R9 window closed", hold_active, 0);
        step();
        chk("R9 capture resumes", int_sts[0], 1);

        // R11: no window when hold disabled or length zero
        hold_enable = 0; db_cfg_wr[2] = 1; step(); db_cfg_wr[2] = 0;
        chk("R11 hold disabled", hold_active, 0);
        chk("R11 readback kept", int_en_rb[0], 1);
        hold_enable = 1; hold_len = 0; db_cfg_wr[1] = 1; step(); db_cfg_wr[1] = 0;
        chk("R11 zero length", hold_active, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule